// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block accepts a byte stream of received frames and stores it in a chain of receive buffers. Each buffer is described by an eight-byte descriptor kept in a byte-wide shared RAM. Processing begins at a programmable table base. The block reads a descriptor, fills the buffer it points to, writes the result back into the descriptor, and then steps to the next descriptor. After a descriptor that carries the wrap flag, it returns to the table base.

A buffer closes when it holds the programmed maximum number of bytes. It also closes early on end-of-frame, on an errored byte, or on an external close command. After such a command, reception carries on in the next buffer. The maximum length is captured when a buffer opens, so a new value affects only later buffers. If the next descriptor is not marked empty, the block signals busy. It then discards incoming bytes and re-reads that descriptor until software hands it back.

Top module: `rbf_ring_filler`

## Requirements
- R1: Writing the table base through `cfg_sel`=0 ignores the low three bits of `cfg_wdata`. After `rx_en` rises, the first descriptor is read at that base. Descriptors follow each other every 8 bytes.
- R2: Descriptor layout: byte 0 holds the status (bit0 empty, bit1 wrap, bit2 last-in-frame, bit3 error), bytes 2/3 hold the byte count low/high, and bytes 4/5 hold the buffer address low/high. The k-th accepted byte of a buffer is written to buffer address + k.
- R3: A buffer that reaches the latched maximum length is closed with count equal to that maximum and with last and error clear. No more bytes are written to it.
- R4: A byte flagged `in_eof` is stored and closes the buffer with the last flag set and the count of stored bytes.
- R5: A byte flagged `in_err` is stored and closes the buffer with the error flag set.
- R6: On close, the status byte is rewritten with empty cleared and the wrap flag kept, and `buf_done` pulses for one cycle. After a descriptor with wrap set, the next descriptor read is at the table base.
- R7: When a fetched descriptor has empty clear, `rx_busy` goes high. `in_ready` stays high, and accepted bytes are dropped without any RAM write. The descriptor is read again until it is found empty.
- R8: The maximum length (`cfg_sel`=1) is captured when a buffer opens. Writing a new value while a buffer is open does not change that buffer's limit.
- R9: `close_req` in a buffer holding at least one byte closes it with last and error clear. The following bytes go into the next descriptor's buffer.
- R10: After reset, `in_ready`, `mem_en`, `rx_busy` and `buf_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low returns the ring pointer to the base at the next fetch |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects maximum buffer length |
| cfg_wdata | input | 16 | Configuration write value, written as one 16-bit word |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted this cycle when high together with in_valid |
| in_data | input | 8 | Stream byte |
| in_eof | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Byte closes the frame with an error |
| close_req | input | 1 | Close the current partially filled buffer |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write (high) or read (low) |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after a read |
| rx_busy | output | 1 | No empty descriptor available; bytes are being dropped |
| buf_done | output | 1 | One-cycle pulse when a descriptor has been written back |

## Verification
The bench writes the base with its low bits set. A design that honoured those bits would fetch garbage and misplace every byte. It lets a frame overrun one buffer and finish in the next, and ends another frame with an error at the wrapping descriptor. A design that wrote past the limit, lost the last or error flag, or failed to return to the base would leave wrong counts, flags or byte placement. It changes the maximum length in the middle of an open buffer, which catches a design that applies the new value immediately through a short first count. A byte sent while the ring is full must not appear in memory. A close command must leave a one-byte buffer without the last flag, and the next byte must land in the next buffer.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_ST,
        S_RD_LO,
        S_RD_HI,
        S_DECIDE,
        S_FILL,
        S_WB_LO,
        S_WB_HI,
        S_WB_ST
    } rbf_state_e;

    // status byte bit positions
    localparam int ST_EMPTY = 0;
    localparam int ST_WRAP  = 1;
    localparam int ST_LAST  = 2;
    localparam int ST_ERR   = 3;

    // byte offsets inside one descriptor
    localparam int OFF_STAT   = 0;
    localparam int OFF_LEN_LO = 2;
    localparam int OFF_LEN_HI = 3;
    localparam int OFF_PTR_LO = 4;
    localparam int OFF_PTR_HI = 5;
    localparam int DESC_BYTES = 8;

    typedef struct packed {
        logic err;
        logic last;
        logic wrap;
        logic empty;
    } rbf_flags_t;

    function automatic logic [7:0] pack_status(rbf_flags_t f);
        logic [7:0] s;
        s = 8'h00;
        s[ST_EMPTY] = f.empty;
        s[ST_WRAP]  = f.wrap;
        s[ST_LAST]  = f.last;
        s[ST_ERR]   = f.err;
        return s;
    endfunction

endpackage

// File: rtl/rbf_cfg_regs.sv
module rbf_cfg_regs #(
    parameter int AW          = 16,
    parameter int LW          = 16,
    parameter int DEF_MAXLEN  = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_sel,
    input  logic [15:0]   cfg_wdata,
    output logic [AW-1:0] base_q,
    output logic [LW-1:0] maxlen_q
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(rbf_pkg::DESC_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            maxlen_q <= LW'(DEF_MAXLEN);
        end else if (cfg_wr) begin
            if (!cfg_sel) base_q   <= AW'(cfg_wdata) & ALIGN_MASK;
            else          maxlen_q <= LW'(cfg_wdata);
        end
    end
endmodule

// File: rtl/rbf_ring_ptr.sv
module rbf_ring_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base,
    input  logic          load_base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] desc_ptr
);
    localparam logic [AW-1:0] STEP = AW'(rbf_pkg::DESC_BYTES);

    always_ff @(posedge clk) begin
        if (rst)            desc_ptr <= '0;
        else if (load_base) desc_ptr <= base;
        else if (advance)   desc_ptr <= wrap ? base : desc_ptr + STEP;
    end
endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl
    import rbf_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic [LW-1:0] cfg_max,
    input  logic [AW-1:0] desc_ptr,
    output logic          ptr_load,
    output logic          ptr_adv,
    output logic          ptr_wrap,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_eof,
    input  logic          in_err,
    input  logic          close_req,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          rx_busy,
    output logic          buf_done,
    output rbf_state_e    state,
    output logic [LW-1:0] fill_cnt,
    output logic [LW-1:0] cur_max
);
    localparam logic [LW-1:0] ONE = LW'(1);

    logic          stat_empty, stat_wrap;
    logic [7:0]    addr_lo;
    logic [AW-1:0] buf_base;
    rbf_flags_t    close_flags;
    logic          take, full_next, end_beat;
    logic [15:0]   len16;

    assign take      = in_valid && (state == S_FILL);
    assign full_next = (fill_cnt + ONE) == cur_max;
    assign end_beat  = in_eof || in_err || full_next;
    assign len16     = 16'(fill_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            rx_busy     <= 1'b0;
            stat_empty  <= 1'b0;
            stat_wrap   <= 1'b0;
            addr_lo     <= '0;
            buf_base    <= '0;
            fill_cnt    <= '0;
            cur_max     <= '0;
            close_flags <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    rx_busy <= 1'b0;
                    if (rx_en) state <= S_RD_ST;
                end
                S_RD_ST: begin
                    if (!rx_en) begin
                        state   <= S_IDLE;
                        rx_busy <= 1'b0;
                    end else begin
                        state <= S_RD_LO;
                    end
                end
                S_RD_LO: begin
                    stat_empty <= mem_rdata[ST_EMPTY];
                    stat_wrap  <= mem_rdata[ST_WRAP];
                    state      <= S_RD_HI;
                end
                S_RD_HI: begin
                    addr_lo <= mem_rdata;
                    state   <= S_DECIDE;
                end
                S_DECIDE: begin
                    if (stat_empty) begin
                        rx_busy  <= 1'b0;
                        buf_base <= AW'({mem_rdata, addr_lo});
                        cur_max  <= cfg_max;
                        fill_cnt <= '0;
                        state    <= S_FILL;
                    end else begin
                        rx_busy <= 1'b1;
                        state   <= S_RD_ST;
                    end
                end
                S_FILL: begin
                    if (take) begin
                        fill_cnt <= fill_cnt + ONE;
                        if (end_beat || close_req) begin
                            close_flags <= '{err: in_err, last: in_eof,
                                             wrap: stat_wrap, empty: 1'b0};
                            state <= S_WB_LO;
                        end
                    end else if (close_req && fill_cnt != '0) begin
                        close_flags <= '{err: 1'b0, last: 1'b0,
                                         wrap: stat_wrap, empty: 1'b0};
                        state <= S_WB_LO;
                    end
                end
                S_WB_LO: state <= S_WB_HI;
                S_WB_HI: state <= S_WB_ST;
                S_WB_ST: state <= S_RD_ST;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_wdata = 8'h00;
        unique case (state)
            S_RD_ST: begin
                mem_en   = 1'b1;
                mem_addr = desc_ptr + AW'(OFF_STAT);
            end
            S_RD_LO: begin
                mem_en   = 1'b1;
                mem_addr = desc_ptr + AW'(OFF_PTR_LO);
            end
            S_RD_HI: begin
                mem_en   = 1'b1;
                mem_addr = desc_ptr + AW'(OFF_PTR_HI);
            end
            S_FILL: begin
                if (take) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = buf_base + AW'(fill_cnt);
                    mem_wdata = in_data;
                end
            end
            S_WB_LO: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + AW'(OFF_LEN_LO);
                mem_wdata = len16[7:0];
            end
            S_WB_HI: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + AW'(OFF_LEN_HI);
                mem_wdata = len16[15:8];
            end
            S_WB_ST: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + AW'(OFF_STAT);
                mem_wdata = pack_status(close_flags);
            end
            default: ;
        endcase
    end

    assign in_ready = (state == S_FILL) || rx_busy;
    assign buf_done = (state == S_WB_ST);
    assign ptr_load = (state == S_IDLE);
    assign ptr_adv  = (state == S_WB_ST);
    assign ptr_wrap = close_flags.wrap;
endmodule

// File: rtl/rbf_ring_filler.sv
module rbf_ring_filler
    import rbf_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LW         = 16,
    parameter int DEF_MAXLEN = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          cfg_wr,
    input  logic          cfg_sel,
    input  logic [15:0]   cfg_wdata,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_eof,
    input  logic          in_err,
    input  logic          close_req,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          rx_busy,
    output logic          buf_done
);
    logic [AW-1:0] base_q;
    logic [LW-1:0] maxlen_q;
    logic [AW-1:0] desc_ptr;
    logic          ptr_load, ptr_adv, ptr_wrap;
    rbf_state_e    ctrl_state;
    logic [LW-1:0] fill_cnt;
    logic [LW-1:0] cur_max;

    rbf_cfg_regs #(.AW(AW), .LW(LW), .DEF_MAXLEN(DEF_MAXLEN)) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .maxlen_q(maxlen_q)
    );

    rbf_ring_ptr #(.AW(AW)) u_ptr (
        .clk(clk), .rst(rst), .base(base_q), .load_base(ptr_load),
        .advance(ptr_adv), .wrap(ptr_wrap), .desc_ptr(desc_ptr)
    );

    rbf_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
        .clk(clk), .rst(rst), .rx_en(rx_en), .cfg_max(maxlen_q),
        .desc_ptr(desc_ptr), .ptr_load(ptr_load), .ptr_adv(ptr_adv),
        .ptr_wrap(ptr_wrap), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_eof(in_eof), .in_err(in_err),
        .close_req(close_req), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rx_busy(rx_busy), .buf_done(buf_done), .state(ctrl_state),
        .fill_cnt(fill_cnt), .cur_max(cur_max)
    );
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker
    import rbf_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_data,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          rx_busy,
    input logic          buf_done,
    input rbf_state_e    ctrl_state,
    input logic [LW-1:0] fill_cnt,
    input logic [LW-1:0] cur_max
);
    // R1: every status read lands on an 8-byte aligned descriptor
    assert_desc_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == S_RD_ST && mem_en) |-> (mem_addr[2:0] == 3'b000));

    // R2: an accepted byte outside the busy state is written to RAM unchanged
    assert_byte_stored_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !rx_busy) |-> (mem_en && mem_we && mem_wdata == in_data));

    // R3: the fill count never passes the latched limit
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == S_FILL) |-> (fill_cnt < cur_max));

    // R6: buf_done lasts exactly one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        buf_done |=> !buf_done);

    // R7: while busy, bytes are taken but nothing is written
    assert_busy_drops_R7: assert property (@(posedge clk) disable iff (rst)
        rx_busy |-> (in_ready && !(mem_en && mem_we)));
endmodule

bind rbf_ring_filler rbf_checker #(.AW(AW), .LW(LW)) u_rbf_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_busy(rx_busy),
    .buf_done(buf_done), .ctrl_state(ctrl_state), .fill_cnt(fill_cnt),
    .cur_max(cur_max)
);

// File: tb/rbf_ring_filler_bench.sv
module rbf_ring_filler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    // {address[11:0], data[7:0], eof, err}
    localparam logic [21:0] VEC [0:NVEC-1] = '{
        {12'h200, 8'hA0, 1'b0, 1'b0},
        {12'h201, 8'hA1, 1'b0, 1'b0},
        {12'h202, 8'hA2, 1'b0, 1'b0},
        {12'h203, 8'hA3, 1'b0, 1'b0},
        {12'h210, 8'hA4, 1'b0, 1'b0},
        {12'h211, 8'hA5, 1'b1, 1'b0},
        {12'h220, 8'hB0, 1'b0, 1'b0},
        {12'h221, 8'hB1, 1'b0, 1'b0},
        {12'h222, 8'hB2, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_eof = 1'b0;
    logic        in_err = 1'b0;
    logic        close_req = 1'b0;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        rx_busy, buf_done;

    logic [7:0]  mem [0:1023];
    int          n_chk = 0;
    int          n_fail = 0;
    int          n_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
        if (!rst && buf_done) n_done <= n_done + 1;
    end

    rbf_ring_filler u_rbf_ring_filler (
        .clk(clk), .rst(rst), .rx_en(rx_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_eof(in_eof),
        .in_err(in_err), .close_req(close_req), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rx_busy(rx_busy), .buf_done(buf_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic eof, input logic err);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_eof = eof; in_err = err;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    endtask

    task automatic wait_busy(input logic lvl);
        @(negedge clk);
        while (rx_busy !== lvl) @(negedge clk);
    endtask

    task automatic set_desc(input int at, input logic [7:0] st, input logic [15:0] ba);
        mem[at + 4] = ba[7:0];
        mem[at + 5] = ba[15:8];
        mem[at]     = st;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset and right after it
        check("R10 in_ready", {31'b0, in_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 mem_en", {31'b0, mem_en}, 0);
        check("R10 rx_busy", {31'b0, rx_busy}, 0);
        check("R10 buf_done", {31'b0, buf_done}, 0);

        cfg_write(1'b0, 16'h0103);   // R1: low bits must be dropped
        cfg_write(1'b1, 16'd4);
        set_desc(16'h100, 8'h01, 16'h0200);
        set_desc(16'h108, 8'h01, 16'h0210);
        set_desc(16'h110, 8'h03, 16'h0220);
        @(negedge clk);
        rx_en = 1'b1;

        for (int i = 0; i < NVEC; i++)
            send(VEC[i][9:2], VEC[i][1], VEC[i][0]);
        wait_busy(1'b1);
        for (int i = 0; i < NVEC; i++)
            check("R1 R2 byte placement", {24'b0, mem[VEC[i][21:10]]}, {24'b0, VEC[i][9:2]});
        check("R3 full status", {24'b0, mem[16'h100]}, 32'h00);
        check("R3 full length", {16'b0, mem[16'h103], mem[16'h102]}, 32'd4);
        check("R4 eof status", {24'b0, mem[16'h108]}, 32'h04);
        check("R4 eof length", {16'b0, mem[16'h10b], mem[16'h10a]}, 32'd2);
        check("R5 err status", {24'b0, mem[16'h110]}, 32'h0A);
        check("R5 err length", {16'b0, mem[16'h113], mem[16'h112]}, 32'd3);
        check("R7 busy raised", {31'b0, rx_busy}, 1);

        send(8'hEE, 1'b0, 1'b0);   // R7: dropped
        repeat (10) @(negedge clk);
        check("R7 dropped byte", {24'b0, mem[16'h223]}, 32'h00);
        check("R7 still busy", {31'b0, rx_busy}, 1);

        set_desc(16'h100, 8'h01, 16'h0300);
        set_desc(16'h108, 8'h01, 16'h0310);
        wait_busy(1'b0);
        send(8'hC0, 1'b0, 1'b0);
        cfg_write(1'b1, 16'd2);     // R8: must not shorten the open buffer
        send(8'hC1, 1'b0, 1'b0);
        send(8'hC2, 1'b0, 1'b0);
        send(8'hC3, 1'b0, 1'b0);
        send(8'hC4, 1'b0, 1'b0);
        send(8'hC5, 1'b0, 1'b0);
        wait_busy(1'b1);
        check("R6 wrap to base", {24'b0, mem[16'h300]}, 32'hC0);
        check("R8 old limit kept", {24'b0, mem[16'h303]}, 32'hC3);
        check("R8 old limit length", {16'b0, mem[16'h103], mem[16'h102]}, 32'd4);
        check("R8 new limit length", {16'b0, mem[16'h10b], mem[16'h10a]}, 32'd2);
        check("R8 new limit data", {16'b0, mem[16'h311], mem[16'h310]}, 32'hC5C4);
        check("R6 wrap flag kept", {24'b0, mem[16'h110]}, 32'h0A);

        set_desc(16'h110, 8'h03, 16'h0320);
        set_desc(16'h100, 8'h01, 16'h0330);
        wait_busy(1'b0);
        send(8'hD0, 1'b0, 1'b0);
        @(negedge clk);
        close_req = 1'b1;
        @(negedge clk);
        close_req = 1'b0;
        send(8'hD1, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check("R9 close status", {24'b0, mem[16'h110]}, 32'h02);
        check("R9 close length", {16'b0, mem[16'h113], mem[16'h112]}, 32'd1);
        check("R9 closed data", {24'b0, mem[16'h320]}, 32'hD0);
        check("R9 continues", {24'b0, mem[16'h330]}, 32'hD1);
        check("R4 eof after close", {24'b0, mem[16'h100]}, 32'h04);
        check("R6 done pulses", n_done, 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule